// File: doc/BRIEF.md
# Counterflow Systolic Four-Tap Convolver

This block computes a four-tap one-dimensional convolution on a linear chain of four processing elements. Each element keeps one coefficient that never moves. Samples enter the chain at one end and step one element per clock toward the far end. Partial sums are born as zero at the far end and step one element per clock back toward the entry end. Each element adds the product of its coefficient and the sample it meets. A sum that has crossed all four elements leaves at the sample entry end as a finished result.

Samples and sums meet at twice the per-clock step. Because of this, samples must arrive with one idle clock between them, and results come out in the same alternating rhythm. A sum is started only when a sample reaches the last element. It carries a valid bit that stays set only while every element it crosses holds a real sample. A window broken by a gap therefore never gives a result. Coefficients are written serially into the chain while the chain is idle.

Top module: `cfir_array`

## Requirements
- R1: While a result is valid, `res_data` equals w1·x(i) + w2·x(i+1) + w3·x(i+2) + w4·x(i+3). Here x(i+3) is the sample accepted at the edge that makes the result valid, and x(i), x(i+1), x(i+2) are the three samples accepted before it.
- R2: A coefficient is written by holding `wld_en` high for one clock with the value on `wld_data`. After four such writes, the first value written is w1 and the fourth is w4. Coefficients are 8-bit two's complement.
- R3: Samples are 8-bit two's complement and results are 18-bit two's complement. No result overflows, including when all samples and coefficients are -128 (result 65536).
- R4: A sample on `smp_data` is accepted at a rising edge only when three things hold: `smp_vld` is high, `wld_en` is low, and no sample was accepted at the previous edge. Otherwise the sample is ignored and never enters any result.
- R5: A result becomes valid at the same edge that accepts the newest sample of its window. After reset, nothing is valid until four samples have been accepted.
- R6: A result is valid only if its four samples were accepted at edges spaced exactly two clocks apart. A longer gap cancels every window that spans it.
- R7: `res_vld` is never high on two clocks in a row.
- R8: `res_data` is zero whenever `res_vld` is low.
- R9: A synchronous active-high `rst` clears all samples and partial sums in flight, and drives `res_vld` and `res_data` low at the next edge. The coefficients are kept through reset.
- R10: A sample offered while `wld_en` is high is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample offered this clock |
| smp_data | input | 8 | Signed sample |
| wld_en | input | 1 | Shift one coefficient into the chain |
| wld_data | input | 8 | Signed coefficient being shifted in |
| res_vld | output | 1 | Result valid |
| res_data | output | 18 | Signed convolution result, zero when not valid |

## Verification
A wrong coefficient, or a sample slot that drifts out of step, corrupts `res_data` on the first valid result after the fault. That result comes at most four accepted samples later, which is seven clocks in steady streaming. A fault in the valid tracking shows as a result where a gap should have cancelled it, or as a missing result. Such a fault is visible on the very clock the window closes. The bench compares every clock of every run against a model that knows only the acceptance rule and the formula, so an early, late or extra valid is caught as soon as it happens.

// File: rtl/cfir_pkg.sv
`timescale 1ns/1ps
package cfir_pkg;
    parameter int N_TAPS = 4;
    parameter int SMP_W  = 8;
    parameter int ACC_W  = 18;
    localparam int WIDE_W = ACC_W + 2;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        logic vld;
        smp_t val;
    } smp_tok_t;

    typedef struct packed {
        logic vld;
        acc_t val;
    } sum_tok_t;

    // multiply-accumulate in the result width
    function automatic acc_t mac(acc_t acc, smp_t x, smp_t w);
        return acc + acc_t'(x) * acc_t'(w);
    endfunction
endpackage

// File: rtl/cfir_gate.sv
`timescale 1ns/1ps
module cfir_gate import cfir_pkg::*; (
    input  logic     in_vld,
    input  smp_t     in_data,
    input  logic     load,
    input  logic     last_taken,
    output smp_tok_t tok
);
    // one idle slot is enforced after every accepted sample
    always_comb begin
        tok.vld = in_vld & ~load & ~last_taken;
        tok.val = tok.vld ? in_data : '0;
    end
endmodule

// File: rtl/cfir_pe.sv
`timescale 1ns/1ps
module cfir_pe import cfir_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  smp_tok_t x_in,
    input  sum_tok_t y_in,
    input  logic     w_shift,
    input  smp_t     w_in,
    output smp_tok_t x_out,
    output sum_tok_t y_out,
    output smp_t     w_out
);
    smp_t     w_r;
    smp_tok_t x_r;
    sum_tok_t y_r;
    logic     meet;
    wide_t    wide_sum;

    assign meet     = x_in.vld & y_in.vld;
    assign wide_sum = wide_t'(y_in.val) + wide_t'(x_in.val) * wide_t'(w_r);

    // coefficients survive reset
    always_ff @(posedge clk) begin
        if (w_shift) w_r <= w_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_r <= '0;
            y_r <= '0;
        end else begin
            x_r     <= x_in;
            y_r.vld <= meet;
            y_r.val <= meet ? mac(y_in.val, x_in.val, w_r) : '0;
        end
    end

    assign x_out = x_r;
    assign y_out = y_r;
    assign w_out = w_r;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        meet |-> (wide_sum[WIDE_W-1:ACC_W-1] == '0 || wide_sum[WIDE_W-1:ACC_W-1] == '1))
        else $error("partial sum overflow"); // R3
endmodule

// File: rtl/cfir_array.sv
`timescale 1ns/1ps
module cfir_array import cfir_pkg::*; #(
    parameter int TAPS = N_TAPS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    wld_en,
    input  logic signed [SMP_W-1:0] wld_data,
    output logic                    res_vld,
    output logic signed [ACC_W-1:0] res_data
);
    localparam int LAST = TAPS - 1;

    smp_tok_t entry_tok;
    smp_tok_t x_q [TAPS];
    sum_tok_t y_q [TAPS];
    smp_t     w_q [TAPS];

    cfir_gate u_gate (
        .in_vld     (smp_vld),
        .in_data    (smp_data),
        .load       (wld_en),
        .last_taken (x_q[0].vld),
        .tok        (entry_tok)
    );

    // element 0 sits at the sample entry and holds the newest-sample tap
    for (genvar k = 0; k < TAPS; k++) begin : g_pe
        smp_tok_t x_feed;
        sum_tok_t y_feed;
        smp_t     w_feed;

        if (k == 0) begin : g_head
            assign x_feed = entry_tok;
            assign w_feed = wld_data;
        end else begin : g_body
            assign x_feed = x_q[k-1];
            assign w_feed = w_q[k-1];
        end

        if (k == LAST) begin : g_tail
            // a zero sum is started whenever a sample reaches the tail
            assign y_feed = '{vld: x_feed.vld, val: '0};
        end else begin : g_mid
            assign y_feed = y_q[k+1];
        end

        cfir_pe u_pe (
            .clk     (clk),
            .rst     (rst),
            .x_in    (x_feed),
            .y_in    (y_feed),
            .w_shift (wld_en),
            .w_in    (w_feed),
            .x_out   (x_q[k]),
            .y_out   (y_q[k]),
            .w_out   (w_q[k])
        );
    end

    assign res_vld  = y_q[0].vld;
    assign res_data = y_q[0].val;

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        res_vld |=> !res_vld) else $error("results adjacent"); // R7

    AST_LOAD_BLOCKS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        wld_en |=> !x_q[0].vld) else $error("sample taken during load"); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> res_data == '0) else $error("idle data nonzero"); // R8

    for (genvar k = 0; k < LAST; k++) begin : g_chk
        AST_SPACING: assert property (@(posedge clk) disable iff (rst)
            res_vld |-> (x_q[k].vld == ((k % 2) == 0)))
            else $error("sample spacing broken"); // R6
    end
endmodule

// File: tb/test_cfir_array.sv
`timescale 1ns/1ps
module test_cfir_array;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_vld = 1'b0;
    logic signed [7:0]  smp_data = '0;
    logic               wld_en = 1'b0;
    logic signed [7:0]  wld_data = '0;
    logic               res_vld;
    logic signed [17:0] res_data;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    int  wm [4];
    int  sh [4];
    int  th [4];
    int  n_acc = 0;
    bit  prev_acc = 1'b0;
    int  cyc = 0;

    always #2 clk = ~clk;

    cfir_array i_cfir_array (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .wld_en(wld_en), .wld_data(wld_data), .res_vld(res_vld), .res_data(res_data)
    );

    function automatic int conv4();
        return wm[0]*sh[0] + wm[1]*sh[1] + wm[2]*sh[2] + wm[3]*sh[3];
    endfunction

    // one clock: drive at negedge, check at the following negedge
    task automatic tick(input bit v, input int d, input bit l, input int ld,
                        input bit r, input string tag);
        bit acc;
        bit ev;
        int ed;
        smp_vld = v; smp_data = d[7:0]; wld_en = l; wld_data = ld[7:0]; rst = r;
        acc = v && !l && !prev_acc && !r;
        ev = 1'b0; ed = 0;
        if (r) begin
            n_acc = 0; prev_acc = 1'b0;
        end else begin
            if (acc) begin
                for (int k = 0; k < 3; k++) begin sh[k] = sh[k+1]; th[k] = th[k+1]; end
                sh[3] = int'($signed(d[7:0])); th[3] = cyc;
                n_acc++;
                if (n_acc >= 4 && th[3]-th[2] == 2 && th[2]-th[1] == 2 && th[1]-th[0] == 2) begin
                    ev = 1'b1; ed = conv4();
                end
            end
            prev_acc = acc;
        end
        if (l) begin
            for (int k = 0; k < 3; k++) wm[k] = wm[k+1];
            wm[3] = int'($signed(ld[7:0]));
        end
        @(negedge clk);
        cyc++;
        n_chk++;
        if (res_vld !== ev || int'(res_data) !== ed) begin
            n_bad++;
            $display("FAIL %s cycle %0d: vld=%0d data=%0d expected vld=%0d data=%0d",
                     tag, cyc, res_vld, int'(res_data), ev, ed);
        end
    endtask

    task automatic load4(input int a, input int b, input int c, input int e);
        tick(0, 0, 1, a, 0, "R2");
        tick(0, 0, 1, b, 0, "R2");
        tick(0, 0, 1, c, 0, "R2");
        tick(0, 0, 1, e, 0, "R2");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, "R8");
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        foreach (wm[k]) begin wm[k] = 0; sh[k] = 0; th[k] = 0; end

        // reset state
        tick(0, 0, 0, 0, 1, "R9");
        tick(0, 0, 0, 0, 1, "R9");
        load4(1, 2, 3, 4);
        idle(2);

        // first result only after four samples, R5 and R1
        for (int i = 1; i <= 6; i++) begin
            tick(1, i, 0, 0, 0, "R5");
            tick(0, 0, 0, 0, 0, "R7");
        end
        idle(6);

        // back-to-back offers: second is dropped, R4
        for (int i = 0; i < 12; i++) tick(1, 10 + i, 0, 0, 0, "R4");
        idle(6);

        // longer gap cancels windows, R6
        tick(1, 5, 0, 0, 0, "R6"); tick(0, 0, 0, 0, 0, "R6");
        tick(1, 6, 0, 0, 0, "R6"); tick(0, 0, 0, 0, 0, "R6"); tick(0, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 5; i++) begin
            tick(1, 7 + i, 0, 0, 0, "R6"); tick(0, 0, 0, 0, 0, "R6");
        end
        idle(6);

        // extremes, R3
        load4(-128, -128, -128, -128);
        idle(2);
        for (int i = 0; i < 6; i++) begin
            tick(1, -128, 0, 0, 0, "R3"); tick(0, 0, 0, 0, 0, "R3");
        end
        idle(6);
        load4(-128, 127, -128, 127);
        idle(2);
        for (int i = 0; i < 6; i++) begin
            tick(1, (i % 2) ? 127 : -128, 0, 0, 0, "R3"); tick(0, 0, 0, 0, 0, "R3");
        end
        idle(6);

        // samples offered during load are ignored, R10
        tick(1, 50, 1, 9, 0, "R10");
        tick(1, 51, 1, -7, 0, "R10");
        tick(1, 52, 1, 3, 0, "R10");
        tick(1, 53, 1, -2, 0, "R10");
        for (int i = 0; i < 5; i++) begin
            tick(1, 20 - i, 0, 0, 0, "R10"); tick(0, 0, 0, 0, 0, "R10");
        end

        // reset mid-stream keeps coefficients, R9
        tick(1, 33, 0, 0, 0, "R9"); tick(0, 0, 0, 0, 0, "R9");
        tick(1, 34, 0, 0, 1, "R9");
        for (int i = 0; i < 5; i++) begin
            tick(1, 40 + i, 0, 0, 0, "R9"); tick(0, 0, 0, 0, 0, "R9");
        end
        idle(6);

        // random sections with fresh coefficients each time, R1
        for (int blk = 0; blk < 20; blk++) begin
            load4($urandom_range(255) - 128, $urandom_range(255) - 128,
                  $urandom_range(255) - 128, $urandom_range(255) - 128);
            idle(2);
            for (int i = 0; i < 300; i++) begin
                bit v;
                v = (blk % 2 == 0) ? ((i % 2) == 0) || ($urandom_range(9) == 0)
                                   : ($urandom_range(9) < 6);
                tick(v, $urandom_range(255) - 128, 0, 0, 0, "R1");
            end
            idle(8);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule